// File: doc/BRIEF.md
# Unsigned Fractional Multiplier with Sign Correction

This unit multiplies two unsigned 16-bit fractional words. Its multiplier core only handles one signed and one unsigned operand. It forces the first operand non-negative by clearing its top bit, then forms the mixed-sign product. If the cleared bit was set, it adds the second operand back as a correction term one word up. The result sits in a 36-bit accumulator: a 4-bit extension above a high word and a low word.

A caller pulses `start` with both operands and a mode bit. The unit steps through five stages, one per clock: load, mask, multiply, correct, and finish. In the finish stage an arithmetic right shift by one is applied when integer mode was chosen. `done` pulses for one cycle when `result` holds the answer. A new request is only taken while the unit is idle.

Top module: `ufrac_mul`

## Requirements
- R1: After reset `result` is all zeros and `done` is low.
- R2: In fractional mode (`intMode` = 0) the final `result` equals 2 × opA × opB, with both operands taken as unsigned 16-bit integers. Bits 35:33 of the result are therefore zero.
- R3: In integer mode (`intMode` = 1) the final `result` equals opA × opB as an unsigned integer. This is the fractional value shifted right arithmetically by one.
- R4: When bit 15 of opA is 0, no correction is added, and the result is the doubled mixed-sign product of the 15 masked bits of opA and opB.
- R5: When bit 15 of opA is 1, opB is added into bits 31:16 of the accumulator with zeros above it (no sign extension). For example, opA = 0x8000 and opB = 0xFFFF give 0x0_FFFF_0000 in fractional mode.
- R6: `done` is high for exactly one cycle. It rises on the fifth rising clock edge counted from, and including, the edge that accepted `start`.
- R7: A `start` pulse while a request is in progress is ignored. The running request finishes with its own result and timing, and no extra `done` follows.
- R8: Operands and mode are sampled on the accepting edge. Changes to `opA`, `opB` or `intMode` after that edge do not affect the result.
- R9: Once `done` has pulsed, `result` holds its value until another request is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, taken only when idle |
| opA | input | 16 | First unsigned fractional operand |
| opB | input | 16 | Second unsigned fractional operand |
| intMode | input | 1 | 1 selects the integer-form result |
| result | output | 36 | Accumulator: extension, high word, low word |
| done | output | 1 | One-cycle pulse when result is final |

## Verification
The bench drives opA values with the top bit set against opB = 0xFFFF. A design that sign-extended the correction term would fill bits 35:32 with ones there. A design that skipped the correction would lose a full half of the product.

Integer mode is checked at the extreme operands. A wrong shift direction, or a shift applied in fractional mode, shows up as a factor-of-two or factor-of-four error.

Extra `start` pulses and operand changes are injected in the middle of a request. A design that restarted, or that sampled its inputs late, would miss the five-edge latency or produce a result from the wrong operands.

// File: rtl/ufrac_mul_pkg.sv
package ufrac_mul_pkg;

  typedef struct packed {
    logic load;
    logic mask;
    logic mul;
    logic corr;
    logic fin;
  } ctrlStrobes_t;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_MASK  = 3'd1,
    ST_MUL   = 3'd2,
    ST_CORR  = 3'd3,
    ST_FIN   = 3'd4
  } ufmState_t;

endpackage

// File: rtl/ufrac_mul_ctrl.sv
module ufrac_mul_ctrl
  import ufrac_mul_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  output ctrlStrobes_t strobes,
  output logic         done
);

  ufmState_t state, nextState;

  always_comb begin
    nextState = state;
    strobes   = '0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strobes.load = 1'b1;
          nextState    = ST_MASK;
        end
      end
      ST_MASK: begin
        strobes.mask = 1'b1;
        nextState    = ST_MUL;
      end
      ST_MUL: begin
        strobes.mul = 1'b1;
        nextState   = ST_CORR;
      end
      ST_CORR: begin
        strobes.corr = 1'b1;
        nextState    = ST_FIN;
      end
      ST_FIN: begin
        strobes.fin = 1'b1;
        nextState   = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= nextState;
      done  <= strobes.fin;
    end
  end

endmodule

// File: rtl/ufrac_mul_dp.sv
module ufrac_mul_dp
  import ufrac_mul_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int EXT_W  = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ctrlStrobes_t                  strobes,
  input  logic [DATA_W-1:0]             opA,
  input  logic [DATA_W-1:0]             opB,
  input  logic                          intMode,
  output logic [EXT_W+2*DATA_W-1:0]     acc
);

  localparam int ACC_W  = EXT_W + 2*DATA_W;
  localparam int PROD_W = 2*DATA_W + 1;
  localparam int PAD_W  = ACC_W - PROD_W - 1;

  logic [DATA_W-1:0] aReg, bReg, aMasked;
  logic              intReg, topBit;

  logic signed [PROD_W-1:0] product;
  logic [ACC_W-1:0]         corrTerm;
  logic [ACC_W-1:0]         accNext;

  assign product  = $signed(aMasked) * $signed({1'b0, bReg});
  assign corrTerm = {{EXT_W{1'b0}}, bReg, {DATA_W{1'b0}}};

  always_comb begin
    accNext = acc;
    if (strobes.mul)
      accNext = {{PAD_W{product[PROD_W-1]}}, product, 1'b0};
    else if (strobes.corr && topBit)
      accNext = acc + corrTerm;
    else if (strobes.fin && intReg)
      accNext = {acc[ACC_W-1], acc[ACC_W-1:1]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aReg    <= '0;
      bReg    <= '0;
      intReg  <= 1'b0;
      aMasked <= '0;
      topBit  <= 1'b0;
      acc     <= '0;
    end else begin
      if (strobes.load) begin
        aReg   <= opA;
        bReg   <= opB;
        intReg <= intMode;
      end
      if (strobes.mask) begin
        aMasked <= {1'b0, aReg[DATA_W-2:0]};
        topBit  <= aReg[DATA_W-1];
      end
      acc <= accNext;
    end
  end

endmodule

// File: rtl/ufrac_mul.sv
module ufrac_mul
  import ufrac_mul_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int EXT_W  = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      start,
  input  logic [DATA_W-1:0]         opA,
  input  logic [DATA_W-1:0]         opB,
  input  logic                      intMode,
  output logic [EXT_W+2*DATA_W-1:0] result,
  output logic                      done
);

  ctrlStrobes_t strobes;

  ufrac_mul_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .strobes (strobes),
    .done    (done)
  );

  ufrac_mul_dp #(
    .DATA_W (DATA_W),
    .EXT_W  (EXT_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .opA     (opA),
    .opB     (opB),
    .intMode (intMode),
    .acc     (result)
  );

endmodule

// File: rtl/ufrac_mul_chk.sv
module ufrac_mul_chk #(
  parameter int DATA_W = 16,
  parameter int EXT_W  = 4
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      start,
  input logic [EXT_W+2*DATA_W-1:0] result,
  input logic                      done
);

  localparam int ACC_W = EXT_W + 2*DATA_W;
  localparam int LAT   = 5;

  logic [2:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cnt <= '0;
    else if (start && (cnt == 3'd0 || cnt == 3'(LAT))) cnt <= 3'd1;
    else if (cnt == 3'(LAT)) cnt <= '0;
    else if (cnt != 3'd0) cnt <= cnt + 3'd1;
  end

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R6 R7
  done_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (cnt == 3'(LAT)));

  // R6
  done_expected_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cnt == 3'(LAT)) |-> done);

  // R2 R3
  result_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (result[ACC_W-1:2*DATA_W+1] == '0));

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> $stable(result));

endmodule

bind ufrac_mul ufrac_mul_chk #(.DATA_W(DATA_W), .EXT_W(EXT_W)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .start  (start),
  .result (result),
  .done   (done)
);

// File: tb/sim_ufrac_mul.sv
module sim_ufrac_mul;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [15:0] opA = '0, opB = '0;
  logic        intMode = 1'b0;
  logic [35:0] result;
  logic        done;

  int checks = 0;
  int errors = 0;
  int edges  = 0;

  always #10 clk = ~clk;

  ufrac_mul u0 (
    .clk(clk), .rstN(rstN), .start(start), .opA(opA), .opB(opB),
    .intMode(intMode), .result(result), .done(done)
  );

  function automatic logic [35:0] expVal(input logic [15:0] a, input logic [15:0] b,
                                         input logic im);
    logic [35:0] p;
    p = 36'(a) * 36'(b);
    return im ? p : (p << 1);
  endfunction

  task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%09h expected 0x%09h", req, act, exp);
    end
  endtask

  task automatic runOp(input logic [15:0] a, input logic [15:0] b, input logic im,
                       input bit disturb, input string req);
    int cycles = 0;
    logic [35:0] held;
    @(negedge clk);
    opA = a; opB = b; intMode = im; start = 1'b1;
    do begin
      @(posedge clk);
      cycles++;
      @(negedge clk);
      start = 1'b0;
      if (disturb) begin
        opA = 16'($urandom); opB = 16'($urandom); intMode = 1'($urandom);
        if (cycles == 2) start = 1'b1;
      end
    end while (!done && cycles < 20);
    start = 1'b0;
    check({req, " R6 latency"}, 36'(cycles), 36'd5);
    check(req, result, expVal(a, b, im));
    @(negedge clk);
    check("R6 done width", 36'(done), 36'd0);
    repeat (2) @(negedge clk);
    held = result;
    check("R9 result held", held, expVal(a, b, im));
    if (disturb) check("R7 no extra done", 36'(done), 36'd0);
  endtask

  initial begin
    void'($urandom(32'd4471));
    repeat (3) @(negedge clk);
    // R1
    check("R1 reset result", result, 36'd0);
    check("R1 reset done", 36'(done), 36'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 post-reset result", result, 36'd0);

    runOp(16'h7FFF, 16'h7FFF, 1'b0, 0, "R4 no correction");
    runOp(16'h0000, 16'hFFFF, 1'b0, 0, "R4 zero operand");
    runOp(16'h8000, 16'hFFFF, 1'b0, 0, "R5 correction no sign ext");
    runOp(16'hFFFF, 16'hFFFF, 1'b0, 0, "R2 max fractional");
    runOp(16'hFFFF, 16'hFFFF, 1'b1, 0, "R3 max integer");
    runOp(16'h8000, 16'h8000, 1'b1, 0, "R3 integer correction");
    runOp(16'h8001, 16'hFFFF, 1'b0, 1, "R7 R8 busy start ignored");
    runOp(16'h1234, 16'hABCD, 1'b1, 1, "R8 late inputs ignored");

    for (int i = 0; i < 200; i++) begin
      logic [15:0] a = 16'($urandom);
      logic [15:0] b = 16'($urandom);
      logic        m = 1'($urandom);
      if (i % 4 == 0) a[15] = 1'b1;
      runOp(a, b, m, (i % 5 == 0), m ? "R3 random" : "R2 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    edges++;
    if (edges > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", edges);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule